// File: doc/BRIEF.md
# System-Management Interrupt Entry Sequencer

This block decides when a processor core leaves normal execution for its system-management service routine and when it comes back. It watches an active-low request pin for a falling edge, checks that a management memory region has been configured, and moves the core into service mode. It also arbitrates the non-maskable interrupt against that entry and holds the NMI while the routine runs. A one-cycle acknowledge pulse marks each entry. The block keeps a select flag that routes bus requests to management memory. It hands the routine its start-up register values. On the first entry after the region is reprogrammed, it works out where the saved-state header sits.

Instruction decode, the bus protocol and the state save itself are handled elsewhere. Strobes stand in for them: a resume strobe, a strobe for the last bus cycle to management memory, and a pair of strobes for the configuration index write and the data access that completes it. The core's configuration registers drive the region enable, base, size and NMI-enable inputs.

Top module: `smm_sequencer`

## Requirements
- R1: A high-to-low transition on `smi_req_n` is synchronised through two flops and then edge-detected. If the pin is driven low just after a rising edge, `in_smm` and the one-cycle `smi_ack` pulse show after the fourth rising edge, and not after the third. Holding the pin low does not cause a second entry.
- R2: A falling edge is dropped, and never remembered, unless `region_en` is 1 and `region_size` is nonzero at the cycle it is detected.
- R3: When an SMI entry and an NMI delivery are both possible in the same cycle, the entry is taken. `nmi_take` stays low and the NMI remains pending.
- R4: While the routine runs, at most one further falling edge is remembered. The block re-enters service one cycle after the resume, and extra edges beyond the first are lost.
- R5: While in service with `nmi_en` at 0, an NMI request is held in `nmi_pending` and not delivered. It is delivered as a one-cycle `nmi_take` pulse one cycle after `nmi_en` is raised, or one cycle after the resume.
- R6: `smm_mem_sel` rises with `smi_ack` and stays high for the whole routine, even if `smm_bus_last_done` pulses during it. After the resume it stays high until the cycle after `smm_bus_last_done` is seen.
- R7: The valid bit of the header pointer is 0 after reset and after any `region_wr` pulse. On an entry with the bit clear, the pointer is loaded with the region base address (`region_base` holding address bits above bit 11) plus the region length, and the bit is set. The length is 4 KiB << (size-1) for size codes 1..14, and the whole 4 GiB address space for code 15, which wraps the sum to the base. While the bit is set, entries leave the pointer unchanged.
- R8: `hdr_ptr` bit 0 is the valid bit, bit 1 reads 0, and bits 31..2 hold the dword-aligned pointer.
- R9: While `in_smm` is 1, `entry_ip` is 0, `entry_flags` is 0000_0002h, `entry_dbg` is 0000_0400h and `entry_cs_base` is the region base address latched at entry. All four read 0 outside service.
- R10: After a `cfg_index_wr` pulse, a pending SMI is not entered until `cfg_data_done` has been seen. Entry follows one cycle after that strobe.
- R11: `rsm_strobe` outside service changes no state. It raises `rsm_illegal` for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smi_req_n | input | 1 | Asynchronous active-low SMI request pin |
| nmi_req | input | 1 | NMI request strobe |
| rsm_strobe | input | 1 | Resume instruction executed |
| smm_bus_last_done | input | 1 | Last bus cycle to management memory has completed |
| cfg_index_wr | input | 1 | Configuration index write observed |
| cfg_data_done | input | 1 | Matching configuration data access completed |
| region_en | input | 1 | Management region enable |
| region_size | input | 4 | Region size code (0 disables) |
| region_base | input | 20 | Region base, address bits 31..12 |
| region_wr | input | 1 | Region register was written |
| nmi_en | input | 1 | Allow NMI delivery while in service |
| in_smm | output | 1 | Service routine active |
| smm_mem_sel | output | 1 | Route bus requests to management memory |
| smi_ack | output | 1 | One-cycle pulse on each entry |
| nmi_pending | output | 1 | An NMI is latched and waiting |
| nmi_take | output | 1 | One-cycle NMI delivery pulse |
| rsm_illegal | output | 1 | Resume seen outside service |
| hdr_ptr | output | 32 | Header pointer, bit 0 valid |
| entry_ip | output | 32 | Instruction pointer at entry |
| entry_flags | output | 32 | Flags value at entry |
| entry_dbg | output | 32 | Debug-control value at entry |
| entry_cs_base | output | 32 | Code segment base at entry |

## Verification
The hardest case to reach from the ports is a collision: a pending SMI and a pending NMI ripen on the same clock edge, or a second edge gets latched while the routine is already running. Either one needs a pin edge placed against the synchroniser latency to within a single cycle. The bench drives the pin low at a counted offset and pulses `nmi_req` exactly one cycle before the SMI becomes pending, so both meet at the entry edge. It also drops two edges inside one routine to show that only one re-entry follows. Seeded random region sizes, bases and enables then sweep the pointer sum, including the wrap at the largest size code and the ignored-request cases.

// File: rtl/smm_pkg.sv
package smm_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_SERVICE = 2'd1,
    ST_DRAIN   = 2'd2
  } smm_state_e;

  localparam logic [REG_W-1:0] IP_AT_ENTRY    = 32'h0000_0000;
  localparam logic [REG_W-1:0] FLAGS_AT_ENTRY = 32'h0000_0002;
  localparam logic [REG_W-1:0] DBG_AT_ENTRY   = 32'h0000_0400;
endpackage

// File: rtl/smi_edge_detect.sv
module smi_edge_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic fall
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= pin_n;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_n};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b1;
    else     last_q <= sync_q[TOP];
  end

  assign fall = last_q & ~sync_q[TOP];

  // R1: an edge is a single-cycle event
  a_r1_single_cycle_fall: assert property (@(posedge clk) disable iff (rst)
    fall |=> !fall);
endmodule

// File: rtl/smm_hdr_ptr.sv
module smm_hdr_ptr #(
  parameter int ADDR_W     = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int SIZE_W     = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] region_base,
  input  logic [SIZE_W-1:0]        region_size,
  input  logic                     region_wr,
  input  logic                     entry,
  output logic [ADDR_W-1:0]        hdr_ptr
);
  localparam int                FULL_CODE = (1 << SIZE_W) - 1;
  localparam int                PW        = ADDR_W - 2;
  localparam logic [PW-1:0]     ONE_W     = {{(PW-1){1'b0}}, 1'b1};

  logic [PW-1:0] base_w;
  logic [PW-1:0] span_w;
  logic [PW-1:0] ptr_next;
  logic [PW-1:0] ptr_q;
  logic          valid_q;

  assign base_w = {region_base, {(PAGE_SHIFT-2){1'b0}}};

  always_comb begin
    if (region_size == '0 || int'(region_size) == FULL_CODE)
      span_w = '0;
    else
      span_w = ONE_W << (PAGE_SHIFT - 3 + int'(region_size));
  end

  assign ptr_next = base_w + span_w;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      if (entry && !valid_q) ptr_q <= ptr_next;
      if (region_wr)                valid_q <= 1'b0;
      else if (entry && !valid_q)   valid_q <= 1'b1;
    end
  end

  assign hdr_ptr = {ptr_q, 1'b0, valid_q};

  // R7: a region write always leaves the pointer invalid
  a_r7_wr_invalidates: assert property (@(posedge clk) disable iff (rst)
    region_wr |=> !valid_q);
  // R7: a valid pointer survives later entries untouched
  a_r7_valid_holds: assert property (@(posedge clk) disable iff (rst)
    valid_q && !region_wr |=> valid_q && $stable(ptr_q));
  // R7: first entry makes the pointer valid
  a_r7_entry_sets: assert property (@(posedge clk) disable iff (rst)
    entry && !region_wr |=> valid_q);
endmodule

// File: rtl/smm_nmi_gate.sv
module smm_nmi_gate (
  input  logic clk,
  input  logic rst,
  input  logic nmi_req,
  input  logic in_service,
  input  logic nmi_en,
  input  logic smi_go,
  output logic nmi_pend,
  output logic nmi_take
);
  logic deliver;

  assign deliver = nmi_pend && (!in_service || nmi_en) && !smi_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_pend <= 1'b0;
      nmi_take <= 1'b0;
    end else begin
      nmi_take <= deliver;
      nmi_pend <= (nmi_pend & ~deliver) | nmi_req;
    end
  end

  // R5: delivery only from a pending request
  a_r5_take_from_pending: assert property (@(posedge clk) disable iff (rst)
    nmi_take |-> $past(nmi_pend));
  // R3: never delivered in a cycle that starts an SMI entry
  a_r3_smi_wins: assert property (@(posedge clk) disable iff (rst)
    nmi_take |-> !$past(smi_go));
endmodule

// File: rtl/smm_ctrl.sv
module smm_ctrl
  import smm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       smi_fall,
  input  logic       recognized,
  input  logic       cfg_index_wr,
  input  logic       cfg_data_done,
  input  logic       rsm_strobe,
  input  logic       last_done,
  output smm_state_e state_q,
  output logic       smi_go,
  output logic       smi_ack,
  output logic       rsm_illegal
);
  logic       cfg_busy_q;
  logic       smi_pend_q;
  logic       blocked;
  smm_state_e state_n;

  assign blocked = cfg_busy_q | cfg_index_wr;
  assign smi_go  = (state_q != ST_SERVICE) && smi_pend_q && !blocked;

  always_ff @(posedge clk) begin
    if (rst)                cfg_busy_q <= 1'b0;
    else if (cfg_index_wr)  cfg_busy_q <= 1'b1;
    else if (cfg_data_done) cfg_busy_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) smi_pend_q <= 1'b0;
    else     smi_pend_q <= (smi_pend_q & ~smi_go) | (smi_fall & recognized);
  end

  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_NORMAL:  if (smi_go) state_n = ST_SERVICE;
      ST_SERVICE: if (rsm_strobe) state_n = ST_DRAIN;
      ST_DRAIN: begin
        if (smi_go)         state_n = ST_SERVICE;
        else if (last_done) state_n = ST_NORMAL;
      end
      default: state_n = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_NORMAL;
      smi_ack     <= 1'b0;
      rsm_illegal <= 1'b0;
    end else begin
      state_q     <= state_n;
      smi_ack     <= smi_go;
      rsm_illegal <= rsm_strobe && (state_q != ST_SERVICE);
    end
  end

  // R2: nothing is latched while the region is unusable
  a_r2_no_latch_disabled: assert property (@(posedge clk) disable iff (rst)
    !recognized && !smi_pend_q |=> !smi_pend_q);
  // R10: no entry while an index/data pair is open
  a_r10_no_entry_busy: assert property (@(posedge clk) disable iff (rst)
    smi_ack |-> $past(!cfg_busy_q && !cfg_index_wr));
  // R4: no entry is taken from inside the routine
  a_r4_no_nested_entry: assert property (@(posedge clk) disable iff (rst)
    smi_ack |-> $past(state_q) != ST_SERVICE);
  // R11: an illegal resume leaves the normal state alone
  a_r11_illegal_no_move: assert property (@(posedge clk) disable iff (rst)
    rsm_illegal && $past(state_q) == ST_NORMAL |-> state_q == ST_NORMAL || smi_ack);
endmodule

// File: rtl/smm_sequencer.sv
module smm_sequencer
  import smm_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int PAGE_SHIFT  = 12,
  parameter int SIZE_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         smi_req_n,
  input  logic                         nmi_req,
  input  logic                         rsm_strobe,
  input  logic                         smm_bus_last_done,
  input  logic                         cfg_index_wr,
  input  logic                         cfg_data_done,
  input  logic                         region_en,
  input  logic [SIZE_W-1:0]            region_size,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] region_base,
  input  logic                         region_wr,
  input  logic                         nmi_en,
  output logic                         in_smm,
  output logic                         smm_mem_sel,
  output logic                         smi_ack,
  output logic                         nmi_pending,
  output logic                         nmi_take,
  output logic                         rsm_illegal,
  output logic [ADDR_W-1:0]            hdr_ptr,
  output logic [REG_W-1:0]             entry_ip,
  output logic [REG_W-1:0]             entry_flags,
  output logic [REG_W-1:0]             entry_dbg,
  output logic [ADDR_W-1:0]            entry_cs_base
);
  smm_state_e state_q;
  logic       smi_fall;
  logic       smi_go;
  logic       recognized;

  assign recognized = region_en && (region_size != '0);

  smi_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst   (rst),
    .pin_n (smi_req_n),
    .fall  (smi_fall)
  );

  smm_ctrl u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .smi_fall      (smi_fall),
    .recognized    (recognized),
    .cfg_index_wr  (cfg_index_wr),
    .cfg_data_done (cfg_data_done),
    .rsm_strobe    (rsm_strobe),
    .last_done     (smm_bus_last_done),
    .state_q       (state_q),
    .smi_go        (smi_go),
    .smi_ack       (smi_ack),
    .rsm_illegal   (rsm_illegal)
  );

  assign in_smm      = (state_q == ST_SERVICE);
  assign smm_mem_sel = (state_q != ST_NORMAL);

  smm_nmi_gate u_nmi (
    .clk        (clk),
    .rst        (rst),
    .nmi_req    (nmi_req),
    .in_service (in_smm),
    .nmi_en     (nmi_en),
    .smi_go     (smi_go),
    .nmi_pend   (nmi_pending),
    .nmi_take   (nmi_take)
  );

  smm_hdr_ptr #(
    .ADDR_W     (ADDR_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .SIZE_W     (SIZE_W)
  ) u_hdr (
    .clk         (clk),
    .rst         (rst),
    .region_base (region_base),
    .region_size (region_size),
    .region_wr   (region_wr),
    .entry       (smi_go),
    .hdr_ptr     (hdr_ptr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      entry_ip      <= '0;
      entry_flags   <= '0;
      entry_dbg     <= '0;
      entry_cs_base <= '0;
    end else if (smi_go) begin
      entry_ip      <= IP_AT_ENTRY;
      entry_flags   <= FLAGS_AT_ENTRY;
      entry_dbg     <= DBG_AT_ENTRY;
      entry_cs_base <= {region_base, {PAGE_SHIFT{1'b0}}};
    end else if (in_smm && rsm_strobe) begin
      entry_ip      <= '0;
      entry_flags   <= '0;
      entry_dbg     <= '0;
      entry_cs_base <= '0;
    end
  end

  // R6: memory select covers the whole routine
  a_r6_sel_in_service: assert property (@(posedge clk) disable iff (rst)
    in_smm |-> smm_mem_sel);
  // R6: release only after the last management bus cycle
  a_r6_release_on_last: assert property (@(posedge clk) disable iff (rst)
    $fell(smm_mem_sel) |-> $past(smm_bus_last_done) && $past(!in_smm));
  // R1: every entry is announced together with service mode
  a_r1_ack_with_entry: assert property (@(posedge clk) disable iff (rst)
    smi_ack |-> in_smm && smm_mem_sel);
  // R5: masked NMI is never delivered inside the routine
  a_r5_nmi_masked: assert property (@(posedge clk) disable iff (rst)
    nmi_take |-> $past(!in_smm || nmi_en));
  // R9: entry flags are present for the whole routine
  a_r9_entry_values: assert property (@(posedge clk) disable iff (rst)
    in_smm |-> entry_flags == FLAGS_AT_ENTRY && entry_dbg == DBG_AT_ENTRY);
endmodule

// File: tb/smm_sequencer_test.sv
module smm_sequencer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        smi_req_n = 1'b1;
  logic        nmi_req = 1'b0;
  logic        rsm_strobe = 1'b0;
  logic        smm_bus_last_done = 1'b0;
  logic        cfg_index_wr = 1'b0;
  logic        cfg_data_done = 1'b0;
  logic        region_en = 1'b0;
  logic [3:0]  region_size = 4'd0;
  logic [19:0] region_base = 20'd0;
  logic        region_wr = 1'b0;
  logic        nmi_en = 1'b0;
  logic        in_smm, smm_mem_sel, smi_ack, nmi_pending, nmi_take, rsm_illegal;
  logic [31:0] hdr_ptr, entry_ip, entry_flags, entry_dbg, entry_cs_base;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  smm_sequencer uut (
    .clk(clk), .rst(rst), .smi_req_n(smi_req_n), .nmi_req(nmi_req),
    .rsm_strobe(rsm_strobe), .smm_bus_last_done(smm_bus_last_done),
    .cfg_index_wr(cfg_index_wr), .cfg_data_done(cfg_data_done),
    .region_en(region_en), .region_size(region_size), .region_base(region_base),
    .region_wr(region_wr), .nmi_en(nmi_en), .in_smm(in_smm),
    .smm_mem_sel(smm_mem_sel), .smi_ack(smi_ack), .nmi_pending(nmi_pending),
    .nmi_take(nmi_take), .rsm_illegal(rsm_illegal), .hdr_ptr(hdr_ptr),
    .entry_ip(entry_ip), .entry_flags(entry_flags), .entry_dbg(entry_dbg),
    .entry_cs_base(entry_cs_base)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_ptr(input logic [19:0] base, input logic [3:0] sz);
    logic [32:0] span;
    if (sz == 4'd0)       span = 33'd0;
    else if (sz == 4'd15) span = 33'h1_0000_0000;
    else                  span = 33'd4096 << (sz - 1);
    exp_ptr = 32'({1'b0, base, 12'h000} + span);
  endfunction

  task automatic pulse_smi();
    smi_req_n = 1'b0; step(1); smi_req_n = 1'b1;
  endtask

  task automatic leave_smm();
    rsm_strobe = 1'b1; step(1); rsm_strobe = 1'b0;
    smm_bus_last_done = 1'b1; step(1); smm_bus_last_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      finish_run();
    end
  end

  initial begin
    logic [31:0] saved;
    void'($urandom(32'd4242));
    step(3);
    rst = 1'b0;
    step(1);
    chk("R7", "reset hdr_ptr", hdr_ptr, 32'h0);
    chk("R6", "reset mem_sel", {31'd0, smm_mem_sel}, 32'd0);
    chk("R9", "reset flags", entry_flags, 32'h0);
    chk("R5", "reset nmi_pending", {31'd0, nmi_pending}, 32'd0);

    // directed entry, R1 latency and level hold
    region_en = 1'b1; region_size = 4'd3; region_base = 20'h00100;
    region_wr = 1'b1; step(1); region_wr = 1'b0;
    smi_req_n = 1'b0;
    step(3);
    chk("R1", "in_smm after 3 edges", {31'd0, in_smm}, 32'd0);
    step(1);
    chk("R1", "in_smm after 4 edges", {31'd0, in_smm}, 32'd1);
    chk("R1", "smi_ack pulse", {31'd0, smi_ack}, 32'd1);
    chk("R6", "mem_sel on ack", {31'd0, smm_mem_sel}, 32'd1);
    chk("R7", "hdr_ptr at entry", hdr_ptr, 32'h0010_4001);
    chk("R8", "hdr_ptr bit1", {31'd0, hdr_ptr[1]}, 32'd0);
    chk("R9", "entry_ip", entry_ip, 32'h0);
    chk("R9", "entry_flags", entry_flags, 32'h2);
    chk("R9", "entry_dbg", entry_dbg, 32'h400);
    chk("R9", "entry_cs_base", entry_cs_base, 32'h0010_0000);
    step(1);
    chk("R1", "ack is one cycle", {31'd0, smi_ack}, 32'd0);
    step(5);
    smi_req_n = 1'b1;
    chk("R1", "level low no retrigger", {31'd0, smi_ack}, 32'd0);

    // R5 masked NMI, R6 drain
    nmi_req = 1'b1; step(1); nmi_req = 1'b0;
    smm_bus_last_done = 1'b1; step(1); smm_bus_last_done = 1'b0;
    step(2);
    chk("R5", "nmi held in service", {31'd0, nmi_take}, 32'd0);
    chk("R5", "nmi pending in service", {31'd0, nmi_pending}, 32'd1);
    chk("R6", "last_done in service ignored", {31'd0, smm_mem_sel}, 32'd1);
    rsm_strobe = 1'b1; step(1); rsm_strobe = 1'b0;
    chk("R6", "in_smm after resume", {31'd0, in_smm}, 32'd0);
    chk("R6", "mem_sel held after resume", {31'd0, smm_mem_sel}, 32'd1);
    chk("R9", "flags cleared after resume", entry_flags, 32'h0);
    step(1);
    chk("R5", "nmi delivered after resume", {31'd0, nmi_take}, 32'd1);
    chk("R5", "nmi pending cleared", {31'd0, nmi_pending}, 32'd0);
    chk("R6", "mem_sel until last_done", {31'd0, smm_mem_sel}, 32'd1);
    smm_bus_last_done = 1'b1; step(1); smm_bus_last_done = 1'b0;
    chk("R6", "mem_sel released", {31'd0, smm_mem_sel}, 32'd0);

    // R7 pointer stays while valid
    saved = hdr_ptr;
    pulse_smi(); step(3);
    chk("R7", "re-entry keeps pointer", hdr_ptr, saved);
    leave_smm();

    // R11 illegal resume
    rsm_strobe = 1'b1; step(1); rsm_strobe = 1'b0;
    chk("R11", "illegal flag", {31'd0, rsm_illegal}, 32'd1);
    chk("R11", "still normal", {31'd0, in_smm}, 32'd0);
    chk("R11", "mem_sel unchanged", {31'd0, smm_mem_sel}, 32'd0);
    chk("R11", "pointer unchanged", hdr_ptr, saved);
    step(1);
    chk("R11", "flag one cycle", {31'd0, rsm_illegal}, 32'd0);

    // R4 one further SMI latched, second extra lost
    pulse_smi(); step(3);
    chk("R4", "entered", {31'd0, in_smm}, 32'd1);
    pulse_smi(); step(5);
    pulse_smi(); step(5);
    chk("R4", "no nested entry", {31'd0, smi_ack}, 32'd0);
    rsm_strobe = 1'b1; step(1); rsm_strobe = 1'b0;
    chk("R4", "left briefly", {31'd0, in_smm}, 32'd0);
    chk("R6", "sel held across re-entry", {31'd0, smm_mem_sel}, 32'd1);
    step(1);
    chk("R4", "re-entered", {31'd0, in_smm}, 32'd1);
    chk("R4", "re-entry ack", {31'd0, smi_ack}, 32'd1);
    leave_smm();
    step(6);
    chk("R4", "only one re-entry", {31'd0, in_smm}, 32'd0);

    // R3 collision of SMI and NMI
    smi_req_n = 1'b0; step(1); smi_req_n = 1'b1; step(1);
    nmi_req = 1'b1; step(1); nmi_req = 1'b0;
    step(1);
    chk("R3", "smi entered first", {31'd0, smi_ack}, 32'd1);
    chk("R3", "nmi not taken", {31'd0, nmi_take}, 32'd0);
    chk("R3", "nmi still pending", {31'd0, nmi_pending}, 32'd1);
    nmi_en = 1'b1; step(1);
    chk("R5", "nmi delivered on enable", {31'd0, nmi_take}, 32'd1);
    nmi_en = 1'b0;
    leave_smm();

    // R10 index/data hold-off
    cfg_index_wr = 1'b1; step(1); cfg_index_wr = 1'b0;
    pulse_smi(); step(6);
    chk("R10", "blocked while open", {31'd0, in_smm}, 32'd0);
    cfg_data_done = 1'b1; step(1); cfg_data_done = 1'b0;
    chk("R10", "not yet on done edge", {31'd0, in_smm}, 32'd0);
    step(1);
    chk("R10", "entry after done", {31'd0, in_smm}, 32'd1);
    leave_smm();

    // random region programming: R2 and R7
    for (int it = 0; it < 40; it++) begin
      logic [3:0]  sz;
      logic [19:0] bs;
      logic        en;
      sz = 4'($urandom_range(0, 15));
      en = ($urandom_range(0, 5) != 0);
      if (sz == 4'd15)     bs = 20'd0;
      else if (sz == 4'd0) bs = 20'($urandom);
      else                 bs = 20'($urandom) & ~((20'd1 << (sz - 1)) - 20'd1);
      region_size = sz; region_base = bs; region_en = en;
      region_wr = 1'b1; step(1); region_wr = 1'b0;
      chk("R7", "valid cleared by region write", {31'd0, hdr_ptr[0]}, 32'd0);
      pulse_smi(); step(3);
      if (en && sz != 4'd0) begin
        chk("R7", "pointer base plus size", hdr_ptr, exp_ptr(bs, sz) | 32'd1);
        chk("R9", "cs base", entry_cs_base, {bs, 12'h000});
        leave_smm();
        chk("R6", "released after exit", {31'd0, smm_mem_sel}, 32'd0);
      end else begin
        chk("R2", "ignored when unusable", {31'd0, in_smm}, 32'd0);
        region_en = 1'b1; region_size = 4'd1;
        step(5);
        chk("R2", "edge not remembered", {31'd0, in_smm}, 32'd0);
      end
    end

    done = 1'b1;
    finish_run();
  end
endmodule